// File: doc/BRIEF.md
# Packed palette RAM write port

This block is a colour lookup table. Each of its 256 entries holds an 8-bit red, an 8-bit green and an 8-bit blue value. A host loads the table through a 32-bit register port. It first writes a start index to an address register. It then writes data words, and each data word carries four colour bytes. The bytes from successive words form one continuous stream in the order red, green, blue, red, green, blue. An entry can therefore begin in one word and end in the next, and three words fill exactly one aligned group of four entries. An internal pointer follows the stream, so a long run of data writes fills the table with no further address writes.

The same address register also selects one of a small set of byte-wide control registers. A control write stores its low byte in the register that the address selects. This path is separate from the palette.

A synchronous lookup port returns the full colour triple of any entry one cycle after the index is presented. Host writes never stall it.

Top module: `clut_pack_wr`

## Requirements
- R1: After reset every entry reads 0x000000, and the first data write lands on entry 0, red component.
- R2: An address write (host_sel = 0) moves the pointer to the written index with its two low bits cleared, red component. For example, 0x07 gives entry 4.
- R3: Within a data word (host_sel = 1), bits [31:24] are the first stream byte and bits [7:0] are the last. Stream bytes fill red, then green, then blue, and then move on to red of the next entry. The lookup output places red in [23:16], green in [15:8] and blue in [7:0].
- R4: Three data writes after an address write of 4k load entries 4k to 4k+3 completely and leave entry 4k+4 untouched.
- R5: A fourth data write continues into the next group with no new address write.
- R6: The pointer wraps from entry 255, blue, to entry 0, red.
- R7: An entry that is only partly written keeps its old value in every component not yet written.
- R8: The lookup output shows the entry that was indexed in the previous cycle. If a write to that entry happens in the same cycle as the index, the output shows the value from before the write.
- R9: A control write (host_sel = 2) stores host_wdata[7:0] in the control register selected by the last address written. It leaves the palette and the pointer unchanged. If the address is 8 or more, nothing is stored. A write with host_sel = 3 changes nothing.
- R10: At reset, control registers 4, 5, 6 and 7 hold 0xFF, 0x00, 0x70 and 0x00. The other control registers hold 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 2 | Target register: 0 address, 1 data, 2 control, 3 none |
| host_wdata | input | 32 | Host write data |
| lut_idx | input | 8 | Lookup index |
| lut_rgb | output | 24 | Colour of the indexed entry, one cycle later |
| ctl_idx | input | 3 | Control register read select |
| ctl_q | output | 8 | Control register contents (combinational) |

## Verification
The bench builds the block with its default parameters: 8 index bits, 8-bit components, a 32-bit bus and eight control registers. With these values, a start index of 252 reaches the wrap from entry 255 to entry 0 in three words. Misaligned start addresses exercise the alignment rule. Every starting component (red, green or blue) occurs in the stream, so all three lane-to-bank mappings and the two-writes-per-bank case are covered. A byte-stream reference model follows the lookup output on every clock.

// File: rtl/clut_pkg.sv
package clut_pkg;
   localparam logic [1:0] SEL_ADDR = 2'd0;
   localparam logic [1:0] SEL_DATA = 2'd1;
   localparam logic [1:0] SEL_CTRL = 2'd2;
   localparam logic [1:0] SEL_NONE = 2'd3;

   function automatic logic [7:0] ctl_reset_value(input int idx);
      case (idx)
         4:       return 8'hFF;
         6:       return 8'h70;
         default: return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/clut_ptr.sv
module clut_ptr #(
   parameter int IDX_W      = 8,
   parameter int LANES      = 4,
   parameter int NCOMP      = 3,
   parameter int ALIGN_BITS = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ld,
   input  logic [IDX_W-1:0]              ld_idx,
   input  logic                          adv,
   output logic [LANES-1:0][IDX_W-1:0]   lane_ent,
   output logic [LANES-1:0][1:0]         lane_comp
);
   localparam int NUM = 1 << IDX_W;
   localparam int STREAM = NUM * NCOMP;
   localparam logic [IDX_W-1:0] ALIGN_MASK = ~IDX_W'((1 << ALIGN_BITS) - 1);

   if (((NCOMP << ALIGN_BITS) % LANES) != 0) begin : g_bad_align
      $error("aligned group must be a whole number of bus words");
   end
   if (NCOMP > 4) begin : g_bad_comp
      $error("component index is two bits wide");
   end

   logic [IDX_W-1:0] entry_q;
   logic [1:0]       comp_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         entry_q <= '0;
         comp_q  <= '0;
      end else if (ld) begin
         entry_q <= ld_idx & ALIGN_MASK;
         comp_q  <= '0;
      end else if (adv) begin
         entry_q <= entry_q + IDX_W'((int'(comp_q) + LANES) / NCOMP);
         comp_q  <= 2'((int'(comp_q) + LANES) % NCOMP);
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_ent[i]  = entry_q + IDX_W'((int'(comp_q) + i) / NCOMP);
      assign lane_comp[i] = 2'((int'(comp_q) + i) % NCOMP);
   end

   // R2
   ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (comp_q == 2'd0) && (entry_q == ($past(ld_idx) & ALIGN_MASK)));

   // R5
   ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ld) |=> ((int'(entry_q) * NCOMP + int'(comp_q)) ==
         ((int'($past(entry_q)) * NCOMP + int'($past(comp_q)) + LANES) % STREAM)));
endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
   parameter int IDX_W  = 8,
   parameter int COMP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_a,
   input  logic [IDX_W-1:0]  idx_a,
   input  logic [COMP_W-1:0] d_a,
   input  logic              we_b,
   input  logic [IDX_W-1:0]  idx_b,
   input  logic [COMP_W-1:0] d_b,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [COMP_W-1:0] rd_q
);
   localparam int DEPTH = 1 << IDX_W;

   logic [COMP_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int j = 0; j < DEPTH; j++) mem[j] <= '0;
         rd_q <= '0;
      end else begin
         rd_q <= mem[rd_idx];
         if (we_a) mem[idx_a] <= d_a;
         if (we_b) mem[idx_b] <= d_b;
      end
   end

   // R4
   port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we_a && we_b) |-> (idx_a != idx_b));
endmodule

// File: rtl/clut_ctl.sv
module clut_ctl #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        waddr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [$clog2(DEPTH)-1:0] rd_idx,
   output logic [DATA_W-1:0]        rd_q
);
   localparam int CAW = $clog2(DEPTH);

   if (DEPTH > (1 << ADDR_W)) begin : g_bad_depth
      $error("control depth exceeds address reach");
   end

   logic [DATA_W-1:0] regs [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[i] <= DATA_W'(clut_pkg::ctl_reset_value(i));
         else if (we && (waddr == ADDR_W'(i)))
            regs[i] <= wdata;
      end
   end

   assign rd_q = regs[rd_idx];

   // R9
   ctl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (int'(waddr) < DEPTH)) |=> (regs[$past(waddr[CAW-1:0])] == $past(wdata)));
endmodule

// File: rtl/clut_pack_wr.sv
module clut_pack_wr #(
   parameter int IDX_W      = 8,
   parameter int COMP_W     = 8,
   parameter int BUS_W      = 32,
   parameter int CTL_DEPTH  = 8,
   parameter int ALIGN_BITS = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          host_we,
   input  logic [1:0]                    host_sel,
   input  logic [BUS_W-1:0]              host_wdata,
   input  logic [IDX_W-1:0]              lut_idx,
   output logic [3*COMP_W-1:0]           lut_rgb,
   input  logic [$clog2(CTL_DEPTH)-1:0]  ctl_idx,
   output logic [7:0]                    ctl_q
);
   import clut_pkg::*;

   localparam int NCOMP = 3;
   localparam int LANES = BUS_W / COMP_W;

   if ((BUS_W % COMP_W) != 0) begin : g_bad_bus
      $error("bus width must hold whole components");
   end
   if (LANES > 2 * NCOMP) begin : g_bad_lanes
      $error("at most two writes per component bank per word");
   end
   if (CTL_DEPTH < 8) begin : g_bad_ctl
      $error("default control set needs eight registers");
   end

   logic ld_addr, adv, ctl_we;
   logic [IDX_W-1:0] addr_q;

   assign ld_addr = host_we && (host_sel == SEL_ADDR);
   assign adv     = host_we && (host_sel == SEL_DATA);
   assign ctl_we  = host_we && (host_sel == SEL_CTRL);

   always_ff @(posedge clk) begin
      if (!rst_n)       addr_q <= '0;
      else if (ld_addr) addr_q <= host_wdata[IDX_W-1:0];
   end

   logic [LANES-1:0][IDX_W-1:0]  lane_ent;
   logic [LANES-1:0][1:0]        lane_comp;
   logic [LANES-1:0][COMP_W-1:0] lane_byte;

   for (genvar i = 0; i < LANES; i++) begin : g_bytes
      assign lane_byte[i] = host_wdata[BUS_W-1-COMP_W*i -: COMP_W];
   end

   clut_ptr #(
      .IDX_W(IDX_W), .LANES(LANES), .NCOMP(NCOMP), .ALIGN_BITS(ALIGN_BITS)
   ) u_ptr (
      .clk(clk), .rst_n(rst_n), .ld(ld_addr), .ld_idx(host_wdata[IDX_W-1:0]),
      .adv(adv), .lane_ent(lane_ent), .lane_comp(lane_comp)
   );

   logic [NCOMP-1:0]             bank_we_b;
   logic [NCOMP-1:0][COMP_W-1:0] rd_q;

   for (genvar c = 0; c < NCOMP; c++) begin : g_bank
      logic              we_a, we_b;
      logic [IDX_W-1:0]  idx_a, idx_b;
      logic [COMP_W-1:0] d_a, d_b;

      always_comb begin
         we_a = 1'b0; idx_a = '0; d_a = '0;
         we_b = 1'b0; idx_b = '0; d_b = '0;
         for (int i = 0; i < NCOMP && i < LANES; i++) begin
            if (adv && lane_comp[i] == 2'(c)) begin
               we_a = 1'b1; idx_a = lane_ent[i]; d_a = lane_byte[i];
            end
         end
         for (int i = NCOMP; i < LANES; i++) begin
            if (adv && lane_comp[i] == 2'(c)) begin
               we_b = 1'b1; idx_b = lane_ent[i]; d_b = lane_byte[i];
            end
         end
      end

      assign bank_we_b[c] = we_b;

      clut_bank #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_bank (
         .clk(clk), .rst_n(rst_n),
         .we_a(we_a), .idx_a(idx_a), .d_a(d_a),
         .we_b(we_b), .idx_b(idx_b), .d_b(d_b),
         .rd_idx(lut_idx), .rd_q(rd_q[c])
      );

      assign lut_rgb[(NCOMP-c)*COMP_W-1 -: COMP_W] = rd_q[c];
   end

   clut_ctl #(.ADDR_W(IDX_W), .DATA_W(8), .DEPTH(CTL_DEPTH)) u_ctl (
      .clk(clk), .rst_n(rst_n), .we(ctl_we), .waddr(addr_q),
      .wdata(host_wdata[7:0]), .rd_idx(ctl_idx), .rd_q(ctl_q)
   );

   // R3
   lane_b_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(bank_we_b) <= LANES - NCOMP);
endmodule

// File: tb/clut_pack_wr_tb.sv
module clut_pack_wr_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [1:0]  host_sel = 2'd3;
   logic [31:0] host_wdata = '0;
   logic [7:0]  lut_idx = '0;
   logic [23:0] lut_rgb;
   logic [2:0]  ctl_idx = '0;
   logic [7:0]  ctl_q;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit cmp_en = 1'b0;

   always #5 clk = ~clk;

   clut_pack_wr u_dut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
      .host_wdata(host_wdata), .lut_idx(lut_idx), .lut_rgb(lut_rgb),
      .ctl_idx(ctl_idx), .ctl_q(ctl_q)
   );

   // byte-stream reference model: entry n occupies bytes 3n..3n+2
   logic [7:0]  mbytes [768];
   int          mpos;
   logic [23:0] exp_rgb;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int j = 0; j < 768; j++) mbytes[j] = 8'h00;
         mpos = 0;
         exp_rgb <= '0;
      end else begin
         exp_rgb <= {mbytes[3*lut_idx], mbytes[3*lut_idx+1], mbytes[3*lut_idx+2]};
         if (host_we && host_sel == 2'd0) begin
            mpos = int'(host_wdata[7:0] & 8'hFC) * 3;
         end else if (host_we && host_sel == 2'd1) begin
            for (int i = 0; i < 4; i++)
               mbytes[(mpos + i) % 768] = host_wdata[31-8*i -: 8];
            mpos = (mpos + 4) % 768;
         end
      end
   end

   // R8: lookup output follows the model every clock
   always @(negedge clk) begin
      if (cmp_en && !done) begin
         checks++;
         if (lut_rgb !== exp_rgb) begin
            errors++;
            $display("FAIL R8 model compare idx=%0d: got %h expected %h", lut_idx, lut_rgb, exp_rgb);
         end
      end
   end

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic host_op(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_sel = sel; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0; host_sel = 2'd3;
   endtask

   task automatic rd(input logic [7:0] idx, output logic [23:0] v);
      @(negedge clk);
      lut_idx = idx;
      @(negedge clk);
      v = lut_rgb;
   endtask

   task automatic ctl_chk(input string tag, input logic [2:0] i, input logic [7:0] exp);
      ctl_idx = i;
      #1;
      check(tag, {24'h0, ctl_q}, {24'h0, exp});
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [23:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_en = 1'b1;

      // R1 reset state
      rd(8'd0, v);   check("R1 entry0", {8'h0, v}, 32'h0);
      rd(8'd255, v); check("R1 entry255", {8'h0, v}, 32'h0);
      // R10 control defaults
      ctl_chk("R10 ctl4", 3'd4, 8'hFF);
      ctl_chk("R10 ctl5", 3'd5, 8'h00);
      ctl_chk("R10 ctl6", 3'd6, 8'h70);
      ctl_chk("R10 ctl7", 3'd7, 8'h00);
      ctl_chk("R10 ctl0", 3'd0, 8'h00);

      // R1 first data write after reset lands on entry 0
      host_op(2'd1, 32'hC1C2C3C4);
      rd(8'd0, v); check("R1 first write entry0", {8'h0, v}, 32'h00C1C2C3);
      rd(8'd1, v); check("R1 first write entry1", {8'h0, v}, 32'h00C40000);

      // R2 misaligned address, R3 byte order, R7 partial entry
      host_op(2'd0, 32'h00000007);
      host_op(2'd1, 32'h11223344);
      rd(8'd4, v); check("R3 entry4", {8'h0, v}, 32'h00112233);
      rd(8'd5, v); check("R7 entry5 partial", {8'h0, v}, 32'h00440000);
      rd(8'd7, v); check("R2 entry7 untouched", {8'h0, v}, 32'h0);

      // R4 three words fill group of four
      host_op(2'd1, 32'h55667788);
      host_op(2'd1, 32'h99AABBCC);
      rd(8'd5, v); check("R4 entry5", {8'h0, v}, 32'h00445566);
      rd(8'd6, v); check("R4 entry6", {8'h0, v}, 32'h00778899);
      rd(8'd7, v); check("R4 entry7", {8'h0, v}, 32'h00AABBCC);
      rd(8'd8, v); check("R4 entry8 untouched", {8'h0, v}, 32'h0);

      // R5 continue into next group
      host_op(2'd1, 32'hDEADBEEF);
      rd(8'd8, v); check("R5 entry8", {8'h0, v}, 32'h00DEADBE);
      rd(8'd9, v); check("R5 entry9", {8'h0, v}, 32'h00EF0000);

      // R9 control path
      host_op(2'd0, 32'h00000005);
      host_op(2'd2, 32'h0000003C);
      ctl_chk("R9 ctl5 written", 3'd5, 8'h3C);
      ctl_chk("R9 ctl4 kept", 3'd4, 8'hFF);
      rd(8'd4, v); check("R9 palette unchanged", {8'h0, v}, 32'h00112233);
      host_op(2'd1, 32'h10203040);
      rd(8'd4, v); check("R9 pointer unmoved e4", {8'h0, v}, 32'h00102030);
      rd(8'd5, v); check("R9 pointer unmoved e5", {8'h0, v}, 32'h00405566);
      host_op(2'd3, 32'hFFFFFFFF);
      rd(8'd5, v); check("R9 sel3 ignored", {8'h0, v}, 32'h00405566);
      host_op(2'd1, 32'h0A0B0C0D);
      rd(8'd5, v); check("R9 after sel3 e5", {8'h0, v}, 32'h00400A0B);
      rd(8'd6, v); check("R9 after sel3 e6", {8'h0, v}, 32'h000C0D99);
      host_op(2'd0, 32'h00000009);
      host_op(2'd2, 32'h00000077);
      for (int i = 0; i < 8; i++) begin
         logic [7:0] e;
         e = (i == 4) ? 8'hFF : (i == 6) ? 8'h70 : (i == 5) ? 8'h3C : 8'h00;
         ctl_chk("R9 out-of-range ignored", 3'(i), e);
      end

      // R6 wrap from 255 to 0
      host_op(2'd0, 32'h000000FC);
      host_op(2'd1, 32'h01020304);
      host_op(2'd1, 32'h05060708);
      host_op(2'd1, 32'h090A0B0C);
      rd(8'd252, v); check("R6 entry252", {8'h0, v}, 32'h00010203);
      rd(8'd255, v); check("R6 entry255", {8'h0, v}, 32'h000A0B0C);
      host_op(2'd1, 32'hF1F2F3F4);
      rd(8'd0, v); check("R6 wrap entry0", {8'h0, v}, 32'h00F1F2F3);
      rd(8'd1, v); check("R6 wrap entry1", {8'h0, v}, 32'h00F40000);

      // R8 simultaneous write and lookup of entry 0
      host_op(2'd0, 32'h00000000);
      @(negedge clk);
      host_we = 1'b1; host_sel = 2'd1; host_wdata = 32'hA1A2A3A4; lut_idx = 8'd0;
      @(negedge clk);
      host_we = 1'b0; host_sel = 2'd3;
      check("R8 old value same cycle", {8'h0, lut_rgb}, 32'h00F1F2F3);
      @(negedge clk);
      check("R8 new value next cycle", {8'h0, lut_rgb}, 32'h00A1A2A3);

      // scan a stretch of the table against the model
      for (int i = 0; i < 16; i++) rd(8'(i), v);

      finish_run();
   end
endmodule